// File: doc/BRIEF.md
# Dual-Mode Half-Band Chroma Resampler

This block is a 55-tap symmetric half-band FIR filter that doubles or halves the sample rate of one chroma channel. A 4:2:2 stream can be lifted to 4:4:4, or a 4:4:4 stream reduced to 4:2:2. The coefficients are fixed. The centre tap is one half, and every other tap at an even distance from the centre is zero. Only 14 distinct side weights and the centre remain, so the datapath adds each symmetric pair of taps before it multiplies.

In interpolate mode, each accepted sample makes the filter step twice: once with the sample and once with an inserted zero. Input therefore arrives at most every second clock, and output runs at the full clock rate. In decimate mode the filter steps on every accepted sample and emits only the result of every second step. The word length changes with the mode, and interpolate results pass through an overflow clamp. The 20-bit result is meant for a later rounding and window-select stage, which lies outside this block.

Top module: `hb_resampler`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is 0 and `out_data` is 0. Reset empties the tap history, clears any pending zero step and sets the decimation phase to even.
- R2: A sample accepted in cycle n gives its first output in cycle n+8: the interpolate result, or the decimate result if that sample is kept.
- R3: With `mode_interp`=1, an accepted sample gives outputs in two consecutive cycles. The first is the filter step with the sample; the second is the step with an inserted zero. `in_valid` in the cycle just after an accepted sample is ignored.
- R4: With `mode_interp`=0, a sample is accepted in every cycle that `in_valid` is high. Only samples with an even index (counting from 0 after reset) produce an output, so two decimate outputs are never adjacent.
- R5: Tap k (k = 0 newest, up to 54) has weight h[k]/4096, with d = k-27. h = 2048 at d=0 and 0 for any other even d. For odd |d| = 1,3,...,27, h = 1296, -420, 240, -160, 114, -84, 62, -46, 33, -23, 15, -9, 5, -2. An impulse therefore yields a response that is symmetric about k=27.
- R6: Let S be the exact sum of h[k]*x[k], with LSB weight 2^-12. The decimate output is bits 24 down to 5 of S: a 24-bit accumulator with LSB 2^-11, cut to its top 20 bits. It wraps and is never clamped.
- R7: The interpolate output is floor(S/64), LSB 2^-6. A value above 262143 becomes 20'h3FFFF, and a value below -262144 becomes 20'hC0000.
- R8: In interpolate mode, an impulse accepted in cycle n (followed by zero samples) yields 55 response values in cycles n+8 through n+62. The largest, h[27], appears in cycle n+35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_interp | input | 1 | 1 = interpolate by 2, 0 = decimate by 2 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 13 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 20 | Filtered sample, two's complement, scaled per mode |

## Verification
In interpolate mode, the inserted-zero step and a newly offered sample can fall in the same cycle, and the zero step must win. The bench provokes this by holding `in_valid` high on every cycle, both during an impulse and during random interpolate traffic. It judges the result against a behavioural model that drops the colliding sample, and it also checks that output pairs stay intact. The clamp is reached in the same cycles as ordinary sample steps by sign-matched patterns of both polarities, and the bench counts the saturated words it sees.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int SMP_W    = 13;
    localparam int COEF_W   = 13;
    localparam int NTAPS    = 55;
    localparam int CTR      = (NTAPS - 1) / 2;
    localparam int NPAIR    = (CTR + 1) / 2;
    localparam int NTERM    = NPAIR + 1;
    localparam int TREE_LV  = $clog2(NTERM);
    localparam int PRE_W    = SMP_W + 1;
    localparam int PROD_W   = PRE_W + COEF_W;
    localparam int SUM_W    = PROD_W + TREE_LV + 1;
    localparam int OUT_W    = 20;
    localparam int ACC_W    = 24;
    localparam int ACC_DROP = ACC_W - OUT_W;
    localparam int DEC_LSB  = 1 + ACC_DROP;
    localparam int INT_LSB  = DEC_LSB + 1;
    localparam int CTR_SH   = COEF_W - 2;
    localparam int LIM_MAG  = 1 << (OUT_W - 2);

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PRE_W-1:0]  pre_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef enum logic {
        MODE_DEC = 1'b0,
        MODE_INT = 1'b1
    } hb_mode_e;

    typedef struct packed {
        logic     vld;
        hb_mode_e mode;
    } hb_tag_t;

    // Side weight for the pair at odd distance 2j+1 from the centre, scale 2^-12.
    function automatic coef_t hb_coef(int j);
        case (j)
            0:  return 13'sd1296;
            1:  return -13'sd420;
            2:  return 13'sd240;
            3:  return -13'sd160;
            4:  return 13'sd114;
            5:  return -13'sd84;
            6:  return 13'sd62;
            7:  return -13'sd46;
            8:  return 13'sd33;
            9:  return -13'sd23;
            10: return 13'sd15;
            11: return -13'sd9;
            12: return 13'sd5;
            13: return -13'sd2;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/hbr_tap_line.sv
module hbr_tap_line
    import hbr_pkg::*;
#(
    parameter int N = NTAPS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    mode_interp,
    input  logic    in_valid,
    input  smp_t    in_data,
    output smp_t    taps_o [N],
    output hb_tag_t tag_o,
    output logic    zero_pend_o
);

    logic zero_pend;
    logic dec_phase;
    logic smp_tick;
    logic step;
    smp_t step_x;

    // A pending zero step always takes the cycle; a sample offered then is dropped.
    always_comb begin
        smp_tick = in_valid && !zero_pend;
        step     = smp_tick || zero_pend;
        step_x   = zero_pend ? '0 : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_pend <= 1'b0;
            dec_phase <= 1'b0;
            tag_o     <= '0;
        end else begin
            zero_pend <= smp_tick && mode_interp;
            if (smp_tick && !mode_interp) begin
                dec_phase <= !dec_phase;
            end
            tag_o.vld  <= step && (zero_pend || mode_interp || !dec_phase);
            tag_o.mode <= (zero_pend || mode_interp) ? MODE_INT : MODE_DEC;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_tap
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    taps_o[k] <= '0;
                end else if (step) begin
                    taps_o[k] <= step_x;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    taps_o[k] <= '0;
                end else if (step) begin
                    taps_o[k] <= taps_o[k-1];
                end
            end
        end
    end

    assign zero_pend_o = zero_pend;

    // R3: after a sample step in interpolate mode, the next step carries a zero
    a_r3_zero_step: assert property (@(posedge clk) disable iff (rst)
        (smp_tick && mode_interp) |=> (step && step_x == '0));

endmodule

// File: rtl/hbr_mac.sv
module hbr_mac
    import hbr_pkg::*;
#(
    parameter int N = NTAPS
) (
    input  logic    clk,
    input  logic    rst,
    input  smp_t    taps_i [N],
    input  hb_tag_t tag_i,
    output sum_t    sum_o,
    output hb_tag_t tag_o
);

    localparam int C      = (N - 1) / 2;
    localparam int NP     = (C + 1) / 2;
    localparam int NLV    = $clog2(NP + 1);
    localparam int NLEAF  = 1 << NLV;
    localparam int NINNER = NLEAF - 1;
    localparam int NSTG   = 2 + NLV;

    pre_t    pre_q  [NP];
    smp_t    ctr_q;
    prod_t   prod_q [NP];
    prod_t   ctr_term_q;
    sum_t    leaf   [NLEAF];
    sum_t    inner  [NINNER];
    hb_tag_t tag_p  [NSTG];

    // Taps at even nonzero distance carry zero weight and are never read.
    logic unused_even_taps;
    always_comb begin
        unused_even_taps = 1'b0;
        for (int k = 1; k < N; k += 2) begin
            unused_even_taps = unused_even_taps ^ (^taps_i[k]);
        end
    end

    // Stage 1: symmetric pre-add, centre tap passed through
    for (genvar j = 0; j < NP; j++) begin : g_pair
        localparam int D = 2 * j + 1;
        always_ff @(posedge clk) begin
            pre_q[j]  <= PRE_W'(taps_i[C-D]) + PRE_W'(taps_i[C+D]);
            prod_q[j] <= PROD_W'(pre_q[j]) * PROD_W'(hb_coef(j));
        end
    end

    // Stage 2 for the centre: weight one half is a plain shift
    always_ff @(posedge clk) begin
        ctr_q      <= taps_i[C];
        ctr_term_q <= PROD_W'(ctr_q) <<< CTR_SH;
    end

    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        if (i < NP) begin : g_prod
            assign leaf[i] = SUM_W'(prod_q[i]);
        end else if (i == NP) begin : g_ctr
            assign leaf[i] = SUM_W'(ctr_term_q);
        end else begin : g_pad
            assign leaf[i] = '0;
        end
    end

    // Registered binary adder tree in heap order; node n sums nodes 2n+1 and 2n+2
    for (genvar n = 0; n < NINNER; n++) begin : g_node
        localparam int L = 2 * n + 1;
        localparam int R = 2 * n + 2;
        if (L >= NINNER) begin : g_from_leaf
            always_ff @(posedge clk) begin
                inner[n] <= leaf[L-NINNER] + leaf[R-NINNER];
            end
        end else begin : g_from_node
            always_ff @(posedge clk) begin
                inner[n] <= inner[L] + inner[R];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSTG; s++) begin
                tag_p[s] <= '0;
            end
        end else begin
            tag_p[0] <= tag_i;
            for (int s = 1; s < NSTG; s++) begin
                tag_p[s] <= tag_p[s-1];
            end
        end
    end

    assign sum_o = inner[0];
    assign tag_o = tag_p[NSTG-1];

endmodule

// File: rtl/hbr_out_fmt.sv
module hbr_out_fmt
    import hbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sum_t             sum_i,
    input  hb_tag_t          tag_i,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    sum_t             q_int;
    logic [OUT_W-1:0] word;
    hb_mode_e         mode_q;

    logic unused_lsbs;
    assign unused_lsbs = ^sum_i[DEC_LSB-1:0];

    always_comb begin
        q_int = sum_i >>> INT_LSB;
        if (tag_i.mode == MODE_INT) begin
            if (q_int > SUM_W'(LIM_MAG - 1)) begin
                word = OUT_W'(LIM_MAG - 1);
            end else if (q_int < -SUM_W'(LIM_MAG)) begin
                word = OUT_W'(-LIM_MAG);
            end else begin
                word = q_int[OUT_W-1:0];
            end
        end else begin
            word = sum_i[DEC_LSB+OUT_W-1:DEC_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            mode_q    <= MODE_DEC;
        end else begin
            out_valid <= tag_i.vld;
            if (tag_i.vld) begin
                out_data <= word;
                mode_q   <= tag_i.mode;
            end
        end
    end

    // R7: interpolate results stay inside the clamp window
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == MODE_INT) |->
            ($signed(out_data) <= $signed(OUT_W'(LIM_MAG - 1)) &&
             $signed(out_data) >= $signed(OUT_W'(-LIM_MAG))));

    // R4: decimate results are never in adjacent cycles
    a_r4_dec_spacing: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == MODE_DEC) |=> !(out_valid && mode_q == MODE_DEC));

    // R3: an interpolate burst always starts with a pair
    a_r3_pair: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q == MODE_INT && !$past(out_valid)) |=> out_valid);

endmodule

// File: rtl/hb_resampler.sv
module hb_resampler
    import hbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_interp,
    input  logic        in_valid,
    input  logic [12:0] in_data,
    output logic        out_valid,
    output logic [19:0] out_data
);

    smp_t    taps [NTAPS];
    hb_tag_t tag_line;
    hb_tag_t tag_mac;
    sum_t    sum_mac;
    logic    zero_pend;

    hbr_tap_line #(.N(NTAPS)) u_line (
        .clk         (clk),
        .rst         (rst),
        .mode_interp (mode_interp),
        .in_valid    (in_valid),
        .in_data     (smp_t'(in_data)),
        .taps_o      (taps),
        .tag_o       (tag_line),
        .zero_pend_o (zero_pend)
    );

    hbr_mac #(.N(NTAPS)) u_mac (
        .clk   (clk),
        .rst   (rst),
        .taps_i(taps),
        .tag_i (tag_line),
        .sum_o (sum_mac),
        .tag_o (tag_mac)
    );

    hbr_out_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .sum_i    (sum_mac),
        .tag_i    (tag_mac),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    // R2: eight cycles from an accepted interpolate sample to its output
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_interp && !zero_pend) |-> ##8 out_valid);

    // R1: reset silences the output
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/tb_hb_resampler.sv
module tb_hb_resampler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_interp = 1'b0;
    logic        in_valid = 1'b0;
    logic [12:0] in_data = '0;
    logic        out_valid;
    logic [19:0] out_data;

    always #4 clk = ~clk;

    hb_resampler dut (
        .clk        (clk),
        .rst        (rst),
        .mode_interp(mode_interp),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int n_hi   = 0;
    int n_lo   = 0;

    bit          exp_v [64];
    logic [19:0] exp_d [64];
    longint      hist  [55];
    bit          zp;
    bit          ph;
    string       seg_req;

    function automatic int side_w(int a);
        case (a)
            1: return 1296;   3: return -420;  5: return 240;   7: return -160;
            9: return 114;    11: return -84;  13: return 62;   15: return -46;
            17: return 33;    19: return -23;  21: return 15;   23: return -9;
            25: return 5;     27: return -2;   default: return 0;
        endcase
    endfunction

    function automatic int wgt(int k);
        int d;
        d = k - 27;
        if (d == 0) return 2048;
        if (d % 2 == 0) return 0;
        return side_w(d < 0 ? -d : d);
    endfunction

    function automatic logic [19:0] shape(longint s, bit interp);
        longint q;
        if (interp) begin
            q = s >>> 6;
            if (q > 262143) q = 262143;
            if (q < -262144) q = -262144;
        end else begin
            q = s >>> 5;
        end
        return q[19:0];
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step_model(longint x, bit keep, bit interp, int c);
        longint s;
        for (int k = 54; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        if (keep) begin
            s = 0;
            for (int k = 0; k < 55; k++) s += longint'(wgt(k)) * hist[k];
            exp_v[(c + 8) % 64] = 1'b1;
            exp_d[(c + 8) % 64] = shape(s, interp);
        end
    endtask

    task automatic run_model(int c);
        if (rst) begin
            for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
            for (int i = 0; i < 55; i++) hist[i] = 0;
            zp = 1'b0;
            ph = 1'b0;
        end else if (zp) begin
            step_model(0, 1'b1, 1'b1, c);
            zp = 1'b0;
        end else if (in_valid) begin
            if (mode_interp) begin
                step_model(longint'($signed(in_data)), 1'b1, 1'b1, c);
                zp = 1'b1;
            end else begin
                step_model(longint'($signed(in_data)), !ph, 1'b0, c);
                ph = !ph;
            end
        end
    endtask

    // Sign-matched pattern sample: the j-th sample lands on tap index base-2j or base-j
    function automatic logic [12:0] pat(int idx, bit neg);
        int v;
        v = (wgt(idx) >= 0) ? 4095 : -4095;
        if (neg) v = -v;
        return 13'(v);
    endfunction

    task automatic drive(int c);
        rst = 1'b0; in_valid = 1'b0; in_data = '0;
        if (c < 5) begin
            rst = 1'b1; seg_req = "R1";
        end else if (c <= 80) begin
            mode_interp = 1'b1; seg_req = "R8";
            in_valid = 1'b1;
            in_data = (c == 5) ? 13'd1000 : 13'd0;
        end else if (c <= 82) begin
            rst = 1'b1;
        end else if (c <= 240) begin
            mode_interp = 1'b1; seg_req = "R3";
            in_valid = ($urandom_range(0, 9) < 7);
            in_data = 13'($urandom);
        end else if (c <= 242) begin
            rst = 1'b1;
        end else if (c <= 362) begin
            mode_interp = 1'b1; seg_req = "R7";
            if ((c - 243) % 2 == 0) begin
                in_valid = 1'b1;
                in_data = ((c - 243) / 2 < 28) ? pat(54 - (c - 243), 1'b0) : 13'd0;
            end
        end else if (c <= 364) begin
            rst = 1'b1;
        end else if (c <= 484) begin
            mode_interp = 1'b1; seg_req = "R7";
            if ((c - 365) % 2 == 0) begin
                in_valid = 1'b1;
                in_data = ((c - 365) / 2 < 28) ? pat(54 - (c - 365), 1'b1) : 13'd0;
            end
        end else if (c <= 486) begin
            rst = 1'b1;
        end else if (c <= 560) begin
            mode_interp = 1'b0; seg_req = "R4";
            in_valid = 1'b1;
            in_data = (c == 487) ? 13'd1000 : 13'd0;
        end else if (c <= 562) begin
            rst = 1'b1;
        end else if (c <= 760) begin
            mode_interp = 1'b0; seg_req = "R6";
            in_valid = ($urandom_range(0, 9) < 8);
            in_data = 13'($urandom);
        end else if (c <= 762) begin
            rst = 1'b1;
        end else if (c <= 900) begin
            mode_interp = 1'b0; seg_req = "R6";
            in_valid = 1'b1;
            in_data = (c - 763 < 55) ? pat(54 - (c - 763), 1'b0) : 13'd0;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        longint got;
        for (int c = 0; c < 910; c++) begin
            @(negedge clk);
            got = longint'($signed(out_data));
            // Cycle-by-cycle comparison with the model
            check(out_valid == exp_v[c % 64], seg_req, "out_valid", longint'(out_valid),
                  longint'(exp_v[c % 64]));
            if (exp_v[c % 64] && out_valid) begin
                check(out_data == exp_d[c % 64], seg_req, "out_data", got,
                      longint'($signed(exp_d[c % 64])));
            end
            exp_v[c % 64] = 1'b0;
            if (out_valid && out_data == 20'h3FFFF && c > 243 && c <= 484) n_hi++;
            if (out_valid && out_data == 20'hC0000 && c > 243 && c <= 484) n_lo++;

            // Directed checks
            if (c <= 5) begin
                check(!out_valid && out_data == '0, "R1", "reset state", got, 0);
            end
            if (c == 12) check(!out_valid, "R2", "no output before n+8", longint'(out_valid), 0);
            if (c == 13) check(out_valid && got == -32, "R2", "first output at n+8", got, -32);
            if (c == 14) check(out_valid && got == 0, "R3", "zero-step partner", got, 0);
            if (c == 14) check(got == 0, "R5", "even offset weight is zero", got, 0);
            if (c == 39) check(got == 20250, "R5", "weight at d=-1", got, 20250);
            if (c == 41) check(got == 20250, "R5", "weight at d=+1", got, 20250);
            if (c == 40) check(out_valid && got == 32000, "R8", "peak at n+35", got, 32000);
            if (c == 67) check(out_valid && got == -32, "R8", "last response at n+62", got, -32);
            if (c == 68) check(got == 0, "R8", "response ends after n+62", got, 0);
            if (c == 495) check(out_valid && got == -63, "R4", "even sample kept", got, -63);
            if (c == 496) check(!out_valid, "R4", "odd sample dropped", longint'(out_valid), 0);
            if (c == 497) check(out_valid && got == 156, "R4", "next even sample", got, 156);

            drive(c);
            run_model(c);
        end
        check(n_hi > 0, "R7", "positive clamp seen", n_hi, 1);
        check(n_lo > 0, "R7", "negative clamp seen", n_lo, 1);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 910);
            finish_run();
        end
    end

endmodule